// File: doc/BRIEF.md
# Coherent Dual-Parameter Transfer Controller

This block moves two 32-bit parameters as one indivisible unit between a two-word staging buffer and two parameter locations in a shared, word-addressed parameter RAM. The two locations need not be adjacent. The host programs one 32-bit control word. That word selects a channel base, two parameter indices, a staging-buffer base, a width mode and a direction, and it carries a start flag. Writing the word with the start flag set launches the transfer. The same host write is held in wait states until both parameters have moved, so software never sees a half-updated pair.

The sequencer always makes four RAM accesses in a fixed order: read source 0, write destination 0, read source 1, write destination 1. Parameter index 0 pairs with buffer word 0, and parameter index 1 pairs with buffer word 1. In the narrow mode only the low three bytes of each destination are written, through byte enables, so the destination's top byte keeps its old value without a read-modify-write. When the pair is complete the block clears the start flag itself and lets the host access finish.

The control state machine has six states:
- `ST_IDLE`: the register is accessible.
- `ST_RD0` and `ST_WR0`: the first parameter moves.
- `ST_RD1` and `ST_WR1`: the second parameter moves.
- `ST_DONE`: the stalled host access completes.

Its transitions are:
- launch: `ST_IDLE` to `ST_RD0`, on a host write with the start flag set.
- fetch-to-store: `ST_RD0` to `ST_WR0`, and `ST_RD1` to `ST_WR1`.
- next-pair: `ST_WR0` to `ST_RD1`.
- finish: `ST_WR1` to `ST_DONE`. The start flag is cleared on this edge.
- release: `ST_DONE` to `ST_IDLE`.

Top module: `cdt_xfer_top`

## Requirements
- R1: After reset the control word reads as 0, `host_ready` is 1 and `ram_req` is 0.
- R2: The control word fields use host_wdata bit positions as follows. Start is bit 31. Channel base is bits 30:26. Buffer base is bits 25:16. Width select is bit 15. Index 0 is bits 14:8. Direction is bit 7. Index 1 is bits 6:0. A host write with bit 31 = 0 stores the word in one cycle with no wait state, and a later read returns it unchanged.
- R3: A host write with bit 31 = 1 launches exactly four RAM accesses, in the order read, write, read, write. A write with bit 31 = 0 makes no RAM access.
- R4: A launching write is held with `host_ready` = 0 for exactly 5 cycles: the launch cycle plus the four RAM cycles. `host_ready` is 0 in every cycle in which `ram_req` is 1.
- R5: The RAM word index of parameter n is the 12-bit concatenation {channel base, index n}.
- R6: The RAM word index of buffer word k (k = 0 or 1) is {1'b0, buffer base, k}.
- R7: The pair selected by index 0 and buffer word 0 is moved first, and the pair selected by index 1 and buffer word 1 is moved second. Each read is followed directly by the matching write.
- R8: With direction = 1, buffer word k is copied to parameter k. With direction = 0, parameter k is copied to buffer word k. The source is not modified.
- R9: With width = 1, destination writes use `ram_be` = 4'b1111. With width = 0, they use 4'b0111, so the destination's bits 31:24 keep their old value.
- R10: After the transfer, the control word reads back with bit 31 cleared and all other fields unchanged. Bit 31 is already 0 in the cycle in which the stalled access completes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| host_sel | input | 1 | Host access to the control word; held until `host_ready` |
| host_wr | input | 1 | 1 = write, 0 = read |
| host_wdata | input | 32 | Control word written by the host |
| host_rdata | output | 32 | Current control word |
| host_ready | output | 1 | Access completes on a clock edge where `host_sel` and this are both 1 |
| ram_req | output | 1 | RAM access strobe |
| ram_we | output | 1 | 1 = write access, 0 = read access |
| ram_addr | output | 12 | RAM word index |
| ram_be | output | 4 | Byte enables for writes; bit 3 is the top byte |
| ram_wdata | output | 32 | Write data (the word returned by the preceding read) |
| ram_rdata | input | 32 | Read data, valid one cycle after a read strobe |

## Verification
The assertions assume two things about the host. First, the host holds `host_sel`, `host_wr` and `host_wdata` steady while `host_ready` is low. Second, the RAM holds `ram_rdata` from the read cycle into the following write cycle. The bench's host tasks drive a request at a falling edge and leave it untouched until the ready flag has been seen high. Its RAM model updates read data only on read strobes. Every table vector puts both parameter words at channel bases of 16 or above. Those word indices can never coincide with the staging buffer, which lies below word 2048. This keeps the expected destination values free of aliasing between source and destination.

// File: rtl/cdt_pkg.sv
package cdt_pkg;

    localparam int CDT_CB_W   = 5;
    localparam int CDT_IDX_W  = 7;
    localparam int CDT_BB_W   = 10;
    localparam int CDT_DATA_W = 32;
    localparam int CDT_BE_W   = CDT_DATA_W / 8;
    localparam int CDT_ADDR_W = CDT_CB_W + CDT_IDX_W;

    // Packed MSB first: field order is the control word bit layout.
    typedef struct packed {
        logic                 go;
        logic [CDT_CB_W-1:0]  chan_base;
        logic [CDT_BB_W-1:0]  buf_base;
        logic                 wide;
        logic [CDT_IDX_W-1:0] idx_a;
        logic                 to_ram;
        logic [CDT_IDX_W-1:0] idx_b;
    } ctrl_t;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_RD0,
        ST_WR0,
        ST_RD1,
        ST_WR1,
        ST_DONE
    } seq_state_e;

endpackage

// File: rtl/cdt_ctrl_reg.sv
module cdt_ctrl_reg
    import cdt_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  wr_en,
    input  ctrl_t wr_word,
    input  logic  clr_go,
    output ctrl_t word_q
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (wr_en) begin
            word_q <= wr_word;
        end else if (clr_go) begin
            word_q.go <= 1'b0;
        end
    end

endmodule

// File: rtl/cdt_addr_gen.sv
module cdt_addr_gen
    import cdt_pkg::*;
#(
    parameter int ADDR_W = CDT_ADDR_W,
    parameter int BE_W   = CDT_BE_W
) (
    input  logic [CDT_CB_W-1:0]  chan_base,
    input  logic [CDT_BB_W-1:0]  buf_base,
    input  logic [CDT_IDX_W-1:0] idx_a,
    input  logic [CDT_IDX_W-1:0] idx_b,
    input  logic                 to_ram,
    input  logic                 wide,
    input  logic                 second,
    input  logic                 store,
    output logic [ADDR_W-1:0]    addr,
    output logic [BE_W-1:0]      be
);

    localparam int PAD_W = ADDR_W - CDT_BB_W - 1;

    logic [ADDR_W-1:0] param_word;
    logic [ADDR_W-1:0] buf_word;
    logic [ADDR_W-1:0] src_word;
    logic [ADDR_W-1:0] dst_word;

    always_comb begin
        param_word = {chan_base, (second ? idx_b : idx_a)};
        buf_word   = {{PAD_W{1'b0}}, buf_base, second};
        src_word   = to_ram ? buf_word   : param_word;
        dst_word   = to_ram ? param_word : buf_word;
        addr       = store ? dst_word : src_word;
        be         = wide ? {BE_W{1'b1}} : {1'b0, {(BE_W-1){1'b1}}};
    end

endmodule

// File: rtl/cdt_seq.sv
module cdt_seq
    import cdt_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       launch,
    output seq_state_e state,
    output logic       mem_req,
    output logic       mem_store,
    output logic       second,
    output logic       clr_go,
    output logic       idle
);

    seq_state_e nxt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= nxt;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (launch) nxt = ST_RD0;
            ST_RD0:  nxt = ST_WR0;
            ST_WR0:  nxt = ST_RD1;
            ST_RD1:  nxt = ST_WR1;
            ST_WR1:  nxt = ST_DONE;
            ST_DONE: nxt = ST_IDLE;
            default: nxt = ST_IDLE;
        endcase
    end

    always_comb begin
        mem_req   = 1'b0;
        mem_store = 1'b0;
        second    = 1'b0;
        clr_go    = 1'b0;
        idle      = 1'b0;
        unique case (state)
            ST_IDLE: idle = 1'b1;
            ST_RD0:  mem_req = 1'b1;
            ST_WR0: begin
                mem_req   = 1'b1;
                mem_store = 1'b1;
            end
            ST_RD1: begin
                mem_req = 1'b1;
                second  = 1'b1;
            end
            ST_WR1: begin
                mem_req   = 1'b1;
                mem_store = 1'b1;
                second    = 1'b1;
                clr_go    = 1'b1;
            end
            ST_DONE: ;
            default: ;
        endcase
    end

endmodule

// File: rtl/cdt_xfer_top.sv
module cdt_xfer_top
    import cdt_pkg::*;
#(
    parameter int DATA_W = CDT_DATA_W,
    parameter int ADDR_W = CDT_ADDR_W,
    parameter int BE_W   = DATA_W / 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              host_sel,
    input  logic              host_wr,
    input  logic [DATA_W-1:0] host_wdata,
    output logic [DATA_W-1:0] host_rdata,
    output logic              host_ready,
    output logic              ram_req,
    output logic              ram_we,
    output logic [ADDR_W-1:0] ram_addr,
    output logic [BE_W-1:0]   ram_be,
    output logic [DATA_W-1:0] ram_wdata,
    input  logic [DATA_W-1:0] ram_rdata
);

    ctrl_t      wr_word;
    ctrl_t      word_q;
    seq_state_e state;
    logic       launch;
    logic       reg_wr;
    logic       mem_req;
    logic       mem_store;
    logic       second;
    logic       clr_go;
    logic       idle;
    logic [BE_W-1:0] be_w;

    assign wr_word = ctrl_t'(host_wdata);
    assign reg_wr  = idle && host_sel && host_wr;
    assign launch  = reg_wr && wr_word.go;

    cdt_ctrl_reg u_reg (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (reg_wr),
        .wr_word (wr_word),
        .clr_go  (clr_go),
        .word_q  (word_q)
    );

    cdt_seq u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .launch    (launch),
        .state     (state),
        .mem_req   (mem_req),
        .mem_store (mem_store),
        .second    (second),
        .clr_go    (clr_go),
        .idle      (idle)
    );

    cdt_addr_gen #(
        .ADDR_W (ADDR_W),
        .BE_W   (BE_W)
    ) u_addr (
        .chan_base (word_q.chan_base),
        .buf_base  (word_q.buf_base),
        .idx_a     (word_q.idx_a),
        .idx_b     (word_q.idx_b),
        .to_ram    (word_q.to_ram),
        .wide      (word_q.wide),
        .second    (second),
        .store     (mem_store),
        .addr      (ram_addr),
        .be        (be_w)
    );

    always_comb begin
        host_rdata = word_q;
        host_ready = (idle && !launch) || (state == ST_DONE);
        ram_req    = mem_req;
        ram_we     = mem_store;
        ram_be     = mem_store ? be_w : {BE_W{1'b0}};
        ram_wdata  = ram_rdata;
    end

endmodule

// File: rtl/cdt_xfer_chk.sv
module cdt_xfer_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        host_ready,
    input logic [31:0] host_rdata,
    input logic        ram_req,
    input logic        ram_we,
    input logic [3:0]  ram_be
);

    assert_we_has_req_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> ram_req);

    assert_stall_during_ram_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ram_req |-> !host_ready);

    assert_read_then_write_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (ram_req && !ram_we) |=> (ram_req && ram_we));

    assert_be_legal_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we |-> (ram_be == 4'b1111 || ram_be == 4'b0111));

    assert_go_cleared_R10: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(ram_we) && host_ready) |-> !host_rdata[31]);

endmodule

bind cdt_xfer_top cdt_xfer_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .host_ready (host_ready),
    .host_rdata (host_rdata),
    .ram_req    (ram_req),
    .ram_we     (ram_we),
    .ram_be     (ram_be)
);

// File: tb/cdt_xfer_top_tb.sv
`timescale 1ns/1ps
module cdt_xfer_top_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        host_sel = 1'b0;
    logic        host_wr = 1'b0;
    logic [31:0] host_wdata = '0;
    logic [31:0] host_rdata;
    logic        host_ready;
    logic        ram_req;
    logic        ram_we;
    logic [11:0] ram_addr;
    logic [3:0]  ram_be;
    logic [31:0] ram_wdata;
    logic [31:0] ram_rdata = '0;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #5 clk = ~clk;

    cdt_xfer_top u_dut (
        .clk (clk), .rst_n (rst_n),
        .host_sel (host_sel), .host_wr (host_wr), .host_wdata (host_wdata),
        .host_rdata (host_rdata), .host_ready (host_ready),
        .ram_req (ram_req), .ram_we (ram_we), .ram_addr (ram_addr),
        .ram_be (ram_be), .ram_wdata (ram_wdata), .ram_rdata (ram_rdata)
    );

    // Sparse RAM model: unwritten words return a pattern of their index.
    logic [31:0] mem [int unsigned];
    int          n_acc = 0;
    logic [11:0] lg_addr [8];
    logic        lg_we   [8];
    logic [3:0]  lg_be   [8];

    function automatic logic [31:0] pat(input logic [11:0] a);
        return {a ^ 12'hA5C, 8'h3C, a};
    endfunction

    function automatic logic [31:0] mread(input logic [11:0] a);
        if (mem.exists(int'(a))) return mem[int'(a)];
        return pat(a);
    endfunction

    always @(posedge clk) begin
        if (rst_n && ram_req) begin
            if (n_acc < 8) begin
                lg_addr[n_acc] = ram_addr;
                lg_we[n_acc]   = ram_we;
                lg_be[n_acc]   = ram_be;
            end
            n_acc = n_acc + 1;
            if (ram_we) begin
                logic [31:0] w;
                w = mread(ram_addr);
                for (int b = 0; b < 4; b++)
                    if (ram_be[b]) w[b*8 +: 8] = ram_wdata[b*8 +: 8];
                mem[int'(ram_addr)] = w;
            end else begin
                ram_rdata <= mread(ram_addr);
            end
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic host_write(input logic [31:0] d, output int waits);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b1; host_wdata = d;
        waits = 0;
        #1;
        while (!host_ready) begin
            waits++;
            @(negedge clk);
            #1;
        end
        @(posedge clk);
        @(negedge clk);
        host_sel = 1'b0; host_wr = 1'b0;
    endtask

    task automatic host_read(output logic [31:0] d);
        @(negedge clk);
        host_sel = 1'b1; host_wr = 1'b0;
        #1;
        d = host_rdata;
        @(posedge clk);
        @(negedge clk);
        host_sel = 1'b0;
    endtask

    // {start, chan base, buf base, width, index0, dir, index1}
    localparam logic [31:0] VEC [6] = '{
        {1'b1, 5'd17, 10'd600,  1'b1, 7'd5,   1'b1, 7'd90},
        {1'b1, 5'd17, 10'd600,  1'b0, 7'd90,  1'b1, 7'd5},
        {1'b1, 5'd20, 10'd3,    1'b1, 7'd0,   1'b0, 7'd127},
        {1'b1, 5'd31, 10'd1023, 1'b0, 7'd127, 1'b0, 7'd0},
        {1'b1, 5'd16, 10'd0,    1'b0, 7'd64,  1'b1, 7'd63},
        {1'b1, 5'd25, 10'd512,  1'b1, 7'd9,   1'b0, 7'd9}
    };

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] rd;
        int waits;
        repeat (3) @(negedge clk);
        #1;
        chk(host_ready == 1'b1, "R1 ready", {31'd0, host_ready}, 32'd1);
        chk(ram_req == 1'b0, "R1 no req", {31'd0, ram_req}, 32'd0);
        rst_n = 1'b1;
        host_read(rd);
        chk(rd == 32'd0, "R1 reset word", rd, 32'd0);

        for (int v = 0; v < 6; v++) begin
            logic [31:0] w, o_s0, o_d0, o_s1, o_d1, e0, e1;
            logic [11:0] p0, p1, b0, b1, s0, d0, s1, d1;
            logic [3:0] ebe;
            w  = VEC[v];
            p0 = {w[30:26], w[14:8]};
            p1 = {w[30:26], w[6:0]};
            b0 = {1'b0, w[25:16], 1'b0};
            b1 = {1'b0, w[25:16], 1'b1};
            s0 = w[7] ? b0 : p0;  d0 = w[7] ? p0 : b0;
            s1 = w[7] ? b1 : p1;  d1 = w[7] ? p1 : b1;
            o_s0 = mread(s0); o_d0 = mread(d0);
            o_s1 = mread(s1); o_d1 = mread(d1);
            e0 = w[15] ? o_s0 : {o_d0[31:24], o_s0[23:0]};
            e1 = w[15] ? o_s1 : {o_d1[31:24], o_s1[23:0]};
            ebe = w[15] ? 4'b1111 : 4'b0111;
            @(negedge clk);
            n_acc = 0;
            host_write(w, waits);
            chk(waits == 5, "R4 wait states", waits, 5);
            chk(n_acc == 4, "R3 access count", n_acc, 4);
            chk({lg_we[0], lg_we[1], lg_we[2], lg_we[3]} == 4'b0101, "R3 rd/wr order",
                {28'd0, lg_we[0], lg_we[1], lg_we[2], lg_we[3]}, 32'h5);
            chk(lg_addr[0] == s0, "R7 R5 R6 first source", {20'd0, lg_addr[0]}, {20'd0, s0});
            chk(lg_addr[1] == d0, "R7 R5 R6 first dest", {20'd0, lg_addr[1]}, {20'd0, d0});
            chk(lg_addr[2] == s1, "R7 R5 R6 second source", {20'd0, lg_addr[2]}, {20'd0, s1});
            chk(lg_addr[3] == d1, "R7 R5 R6 second dest", {20'd0, lg_addr[3]}, {20'd0, d1});
            chk(lg_be[1] == ebe && lg_be[3] == ebe, "R9 byte enables",
                {24'd0, lg_be[1], lg_be[3]}, {24'd0, ebe, ebe});
            chk(mread(d0) == e0, "R8 R9 dest0 value", mread(d0), e0);
            chk(mread(d1) == e1, "R8 R9 dest1 value", mread(d1), e1);
            chk(mread(s0) == o_s0, "R8 source0 kept", mread(s0), o_s0);
            host_read(rd);
            chk(rd == {1'b0, w[30:0]}, "R10 start cleared", rd, {1'b0, w[30:0]});
        end

        begin
            logic [31:0] w;
            w = {1'b0, 5'd21, 10'd77, 1'b1, 7'd33, 1'b1, 7'd44};
            @(negedge clk);
            n_acc = 0;
            host_write(w, waits);
            chk(waits == 0, "R2 no wait", waits, 0);
            chk(n_acc == 0, "R3 no access without start", n_acc, 0);
            host_read(rd);
            chk(rd == w, "R2 field readback", rd, w);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule